// File: doc/BRIEF.md
# Fixed-Point Square Root Unit

This block returns the square root of an unsigned fixed-point operand. The operand and the result share one format: `W` bits in total, of which `F` are fractional. The operand's leading zeros are counted and shifted out, which gives a value in [1.0, 2.0). A table of 16 equal segments supplies a starting estimate of the reciprocal square root. A Newton-Raphson loop then refines that estimate for a chosen number of passes. The refined reciprocal is corrected for the exponent left by the normalization, multiplied by the original operand, and shifted to the output format.

A single pipelined multiplier serves every product inside the block: the three products of each refinement pass, the exponent correction and the final operand product. A caller pulses `req_i` for one cycle with the operand and the pass count. The block answers with a one-cycle `ready_o` pulse and holds `root_o` until the next answer. A request that arrives while an operation is in flight abandons that operation and starts again from normalization.

Top module: `fxp_sqrt`

## Requirements
- R1: With a pass count of 2 or more, `root_o` differs from 2^F·sqrt(operand/2^F) by no more than 1.5 LSB.
- R2: Every leading-zero count from 0 to W-1 is normalized correctly. Operands 2^k and 2^(k+1)-1 for every k meet the accuracy of R1.
- R3: The 16-segment starting estimate is close enough that one pass gives a result within a relative error of 1e-3 plus 1.5 LSB.
- R4: Where the exponent left by normalization is odd, the reciprocal is scaled by 1/sqrt(2) before the operand product. Operands 2^k for odd and even k both meet R1.
- R5: `iters_i` (3 bits) sets the number of refinement passes from 1 to 7. A value of 0 acts as 1 and gives the same result and latency as 1. Counts of 3 and 7 still meet R1.
- R6: An operand of zero skips refinement and returns `root_o` = 0 with a normal `ready_o` pulse. No nonzero operand returns 0.
- R7: `ready_o` is high for exactly one cycle per answer. `root_o` changes only in a cycle where `ready_o` is high.
- R8: A request during a running operation discards it. Exactly one `ready_o` pulse follows, and it carries the root of the newer operand.
- R9: A request driven in the cycle in which `ready_o` is high leaves that answer intact. `root_o` keeps the old value until the new operation's pulse, which carries the new root.
- R10: After reset, `ready_o` is 0 and `root_o` is 0.
- R11: For a nonzero operand, the number of cycles from request to `ready_o` depends only on the pass count. Three input pipeline stages precede the refinement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Start pulse; samples `operand_i` and `iters_i` |
| operand_i | input | W | Unsigned operand, F fractional bits |
| iters_i | input | ITW | Number of refinement passes (0 treated as 1) |
| ready_o | output | 1 | One-cycle pulse when `root_o` is updated |
| root_o | output | W | Square root, F fractional bits, held between pulses |

## Verification
Two events can fall in the same cycle: the answer pulse of one operation and the request for the next. The bench waits for a pulse and drives the next request in that very cycle. It then checks that the old root stays on `root_o` through every cycle until the new pulse, and that the new pulse carries the new operand's root. The restart path is provoked separately: a second request arrives a few cycles into an operation, and in another run on the cycle right after the first. The bench then checks that only one pulse follows and that it belongs to the newer operand.

// File: rtl/fxp_sqrt_pkg.sv
// Package: shared state type and constant-evaluation helpers for the
// square root unit. Assumes constants fit in 64-bit unsigned arithmetic.
package fxp_sqrt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IT0,
        ST_IT1,
        ST_ITW,
        ST_PO0,
        ST_POW1,
        ST_POW2
    } sq_state_t;

    // Integer floor square root, bit by bit; argument below 2^62.
    function automatic longint unsigned isqrt_u64(input longint unsigned n);
        longint unsigned r;
        longint unsigned t;
        r = 0;
        for (int b = 31; b >= 0; b--) begin
            t = r | (64'd1 << b);
            if (t * t <= n) r = t;
        end
        return r;
    endfunction

    // Reciprocal square root of the midpoint of segment i in [1,2),
    // scaled by 2^frac.
    function automatic longint unsigned seed_value(input int i, input int frac,
                                                   input int sb);
        longint unsigned den;
        longint unsigned num;
        den = (64'd1 << (sb + 1)) + 64'(2 * i + 1);
        num = (64'd1 << (sb + 1)) << (2 * frac);
        return isqrt_u64(num / den);
    endfunction

endpackage

// File: rtl/fxp_sqrt_norm.sv
// Leading-zero counter and normalizing shifter.
// Examines at most LZ_DEPTH top bits, which bounds the shifter depth.
// Assumes LZ_DEPTH <= W; a zero input yields a count of LZ_DEPTH.
module fxp_sqrt_norm #(
    parameter int W        = 18,
    parameter int LZ_DEPTH = 18,
    parameter int LZW      = $clog2(W + 1)
) (
    input  logic [W-1:0]   val_i,
    output logic [LZW-1:0] lz_o,
    output logic [W-1:0]   norm_o
);

    // Count zeros above the first set bit within the examined window.
    always_comb begin
        logic found;
        found = 1'b0;
        lz_o  = '0;
        for (int i = W - 1; i >= W - LZ_DEPTH; i--) begin
            if (!found) begin
                if (val_i[i]) found = 1'b1;
                else          lz_o  = lz_o + LZW'(1);
            end
        end
    end

    // Shift the leading one up to the top bit.
    assign norm_o = val_i << lz_o;

endmodule

// File: rtl/fxp_sqrt_seed.sv
// Starting estimate of 1/sqrt(s) for s in [1,2), from 2^SEG_BITS equal
// segments evaluated at their midpoints. Table contents are computed
// at elaboration. Assumes 2*IF + SEG_BITS + 1 <= 62.
module fxp_sqrt_seed #(
    parameter int IW       = 24,
    parameter int IF       = 22,
    parameter int SEG_BITS = 4
) (
    input  logic [SEG_BITS-1:0] idx_i,
    output logic [IW-1:0]       seed_o
);
    import fxp_sqrt_pkg::*;

    localparam int SEGS = 1 << SEG_BITS;

    logic [IW-1:0] tbl [SEGS];

    // One constant per segment.
    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        assign tbl[g] = IW'(seed_value(g, IF, SEG_BITS));
    end

    // Select the segment of the operand.
    assign seed_o = tbl[idx_i];

endmodule

// File: rtl/fxp_sqrt_mul.sv
// Pipelined unsigned multiplier with LAT register stages, shared by all
// products of the square root unit. A flush empties the valid pipeline.
// Assumes LAT >= 1.
module fxp_sqrt_mul #(
    parameter int IW  = 24,
    parameter int LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            vld_i,
    input  logic [IW-1:0]   a_i,
    input  logic [IW-1:0]   b_i,
    output logic            vld_o,
    output logic [2*IW-1:0] prod_o
);

    logic [2*IW-1:0] pr [LAT];
    logic            vl [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Form the product in the first stage.
            always_ff @(posedge clk) begin
                pr[0] <= (2 * IW)'(a_i) * (2 * IW)'(b_i);
            end
            // Track validity of the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n || flush_i) vl[0] <= 1'b0;
                else                   vl[0] <= vld_i;
            end
        end else begin : g_next
            // Carry the product down the pipeline.
            always_ff @(posedge clk) begin
                pr[g] <= pr[g-1];
            end
            // Carry validity down the pipeline.
            always_ff @(posedge clk) begin
                if (!rst_n || flush_i) vl[g] <= 1'b0;
                else                   vl[g] <= vl[g-1];
            end
        end
    end

    assign vld_o  = vl[LAT-1];
    assign prod_o = pr[LAT-1];

endmodule

// File: rtl/fxp_sqrt.sv
// Fixed-point square root: normalize, seed, Newton-Raphson reciprocal
// square root, odd-exponent correction, operand product, final shift.
// Assumes W-1 >= SEG_BITS, GUARD >= 0, W <= 24 (64-bit constants),
// and LZ_DEPTH = W for full operand range.
module fxp_sqrt #(
    parameter int W        = 18,
    parameter int F        = 15,
    parameter int GUARD    = 6,
    parameter int MUL_LAT  = 2,
    parameter int LZ_DEPTH = 18,
    parameter int ITW      = 3,
    parameter int SEG_BITS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic [W-1:0]   operand_i,
    input  logic [ITW-1:0] iters_i,
    output logic           ready_o,
    output logic [W-1:0]   root_o
);
    import fxp_sqrt_pkg::*;

    localparam int IW    = W + GUARD;
    localparam int IF    = IW - 2;
    localparam int LZW   = $clog2(W + 1);
    localparam int SHW   = $clog2(2 * IW);
    localparam int EBASE = W - 1 - F;
    localparam logic [IW-1:0] ONE       = IW'(64'd1 << IF);
    localparam logic [IW-1:0] INV_SQRT2 = IW'(isqrt_u64(64'd1 << (2 * IF - 1)));

    // input pipeline
    logic           v1, v2;
    logic [W-1:0]   op1, op2, m2;
    logic [ITW-1:0] it1, it2;
    logic [LZW-1:0] lz2;
    logic [LZW-1:0] lz_c;
    logic [W-1:0]   norm_c;
    logic [IW-1:0]  seed_c;
    logic [SHW-1:0] sh_c;
    logic           odd_c;

    // core state
    sq_state_t      state;
    logic [W-1:0]   a_q;
    logic [IW-1:0]  s_q, x_q, hx_q, xx_q;
    logic [ITW-1:0] left_q;
    logic [SHW-1:0] sh_q;
    logic           odd_q;
    logic [1:0]     rc_q;
    logic           ready_q;
    logic [W-1:0]   root_q;

    // multiplier
    logic            mi_v, mul_vo;
    logic [IW-1:0]   mi_a, mi_b, mq, xn;
    logic [2*IW-1:0] mp;

    fxp_sqrt_norm #(.W(W), .LZ_DEPTH(LZ_DEPTH), .LZW(LZW)) u_norm (
        .val_i  (op1),
        .lz_o   (lz_c),
        .norm_o (norm_c)
    );

    fxp_sqrt_seed #(.IW(IW), .IF(IF), .SEG_BITS(SEG_BITS)) u_seed (
        .idx_i  (m2[W-2 -: SEG_BITS]),
        .seed_o (seed_c)
    );

    fxp_sqrt_mul #(.IW(IW), .LAT(MUL_LAT)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (req_i),
        .vld_i   (mi_v),
        .a_i     (mi_a),
        .b_i     (mi_b),
        .vld_o   (mul_vo),
        .prod_o  (mp)
    );

    // Product rescaled to the Q2.IF working format.
    assign mq = mp[IF +: IW];
    // Newton-Raphson update: 1.5x - 0.5*(x^2)*(s*x).
    assign xn = hx_q - (mq >> 1);

    // Exponent left by normalization, its parity and the final shift.
    always_comb begin
        int e_v;
        int sh_v;
        e_v   = EBASE - int'(lz2);
        sh_v  = IF + (e_v >>> 1);
        sh_c  = SHW'(sh_v);
        odd_c = e_v[0];
    end

    // Choose what the shared multiplier receives this cycle.
    always_comb begin
        mi_v = 1'b0;
        mi_a = x_q;
        mi_b = x_q;
        if (!req_i) begin
            case (state)
                ST_IT0:  mi_v = 1'b1;
                ST_IT1:  begin mi_v = 1'b1; mi_a = s_q; end
                ST_PO0:  begin mi_v = 1'b1; mi_b = odd_q ? INV_SQRT2 : ONE; end
                ST_POW1: begin mi_v = mul_vo; mi_a = mq; mi_b = IW'(a_q); end
                default: ;
            endcase
            if ((state == ST_IT1 || state == ST_ITW) && mul_vo && rc_q == 2'd1) begin
                mi_v = 1'b1;
                mi_a = xx_q;
                mi_b = mq;
            end
        end
    end

    // Input pipeline stages one and two: capture, then normalize.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1  <= 1'b0;
            v2  <= 1'b0;
            op1 <= '0;
            it1 <= '0;
            op2 <= '0;
            it2 <= '0;
            m2  <= '0;
            lz2 <= '0;
        end else begin
            v1 <= req_i;
            v2 <= v1 & ~req_i;
            if (req_i) begin
                op1 <= operand_i;
                it1 <= (iters_i == '0) ? ITW'(1) : iters_i;
            end
            if (v1) begin
                op2 <= op1;
                it2 <= it1;
                m2  <= norm_c;
                lz2 <= lz_c;
            end
        end
    end

    // Stage three launch and the sequencing of iterations and post steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            a_q     <= '0;
            s_q     <= '0;
            x_q     <= '0;
            hx_q    <= '0;
            xx_q    <= '0;
            left_q  <= '0;
            sh_q    <= '0;
            odd_q   <= 1'b0;
            rc_q    <= '0;
            ready_q <= 1'b0;
            root_q  <= '0;
        end else begin
            ready_q <= 1'b0;
            if (req_i) begin
                state <= ST_IDLE;
            end else if (v2) begin
                a_q    <= op2;
                s_q    <= IW'(m2) << (IF - (W - 1));
                x_q    <= seed_c;
                left_q <= it2;
                sh_q   <= sh_c;
                odd_q  <= odd_c;
                rc_q   <= '0;
                if (op2 == '0) begin
                    root_q  <= '0;
                    ready_q <= 1'b1;
                    state   <= ST_IDLE;
                end else begin
                    state <= ST_IT0;
                end
            end else begin
                case (state)
                    ST_IT0: begin
                        hx_q  <= x_q + (x_q >> 1);
                        rc_q  <= '0;
                        state <= ST_IT1;
                    end
                    ST_IT1, ST_ITW: begin
                        if (state == ST_IT1) state <= ST_ITW;
                        if (mul_vo) begin
                            case (rc_q)
                                2'd0: begin xx_q <= mq; rc_q <= 2'd1; end
                                2'd1: rc_q <= 2'd2;
                                default: begin
                                    x_q  <= xn;
                                    rc_q <= '0;
                                    if (left_q > ITW'(1)) begin
                                        left_q <= left_q - ITW'(1);
                                        state  <= ST_IT0;
                                    end else begin
                                        state <= ST_PO0;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_PO0:  state <= ST_POW1;
                    ST_POW1: if (mul_vo) state <= ST_POW2;
                    ST_POW2: begin
                        if (mul_vo) begin
                            root_q  <= W'(mp >> sh_q);
                            ready_q <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign ready_o = ready_q;
    assign root_o  = root_q;

    // R7: the answer strobe lasts one cycle.
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> !ready_q);

    // R7: the result register moves only together with the strobe.
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_q |-> $stable(root_q));

    // R6: a zero root is returned exactly for a zero operand.
    a_r6_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> ((root_q == '0) == (a_q == '0)));

    // R8: no multiplier result surfaces once the sequencer is idle.
    a_r8_no_stale_product: assert property (@(posedge clk) disable iff (!rst_n)
        mul_vo |-> (state != ST_IDLE));

    // R2: a nonzero operand reaches stage two with its top bit set.
    if (LZ_DEPTH >= W - 1) begin : g_norm_chk
        a_r2_normalized: assert property (@(posedge clk) disable iff (!rst_n)
            (v2 && op2 != '0) |-> m2[W-1]);
    end

    // R1: the refined reciprocal lies in (0.5, 1.0] before correction.
    a_r1_iterate_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PO0) |-> ((x_q <= ONE) && (x_q > (ONE >> 1))));

endmodule

// File: tb/sim_fxp_sqrt.sv
`timescale 1ns/1ps
module sim_fxp_sqrt;
    localparam int W   = 18;
    localparam int F   = 15;
    localparam int ITW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req = 1'b0;
    logic [W-1:0]   operand = '0;
    logic [ITW-1:0] iters = '0;
    logic           ready;
    logic [W-1:0]   root;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  lat_ref [8];

    fxp_sqrt #(.W(W), .F(F), .GUARD(6), .MUL_LAT(2), .LZ_DEPTH(W),
               .ITW(ITW), .SEG_BITS(4)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .operand_i (operand),
        .iters_i   (iters),
        .ready_o   (ready),
        .root_o    (root)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", rq, msg);
        end
    endtask

    function automatic real exp_root(input int a);
        return $sqrt(real'(a) / (2.0 ** F)) * (2.0 ** F);
    endfunction

    // Compare a root with the ideal value under the pass-count tolerance.
    task automatic chk_root(input int a, input logic [W-1:0] r, input int it,
                            input string rq);
        real e, tol, err;
        e   = exp_root(a);
        tol = (it >= 2) ? 1.5 : e * 1.0e-3 + 1.5;
        err = real'(r) - e;
        chk(err <= tol && err >= -tol, rq,
            $sformatf("operand %0d passes %0d: actual %0d expected %f", a, it, r, e));
    endtask

    // Issue one request and wait for the answer pulse; returns at that negedge.
    task automatic do_op(input int a, input int it, output logic [W-1:0] r,
                         output int lat);
        @(negedge clk);
        req = 1'b1; operand = W'(a); iters = ITW'(it);
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!ready && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        chk(ready, "R11", $sformatf("no answer for %0d: actual 0 expected 1", a));
        r = root;
    endtask

    // Full check of one nonzero operand: accuracy plus constant latency (R11).
    task automatic run_val(input int a, input int it, input string rq);
        logic [W-1:0] r;
        int lat;
        do_op(a, it, r, lat);
        chk_root(a, r, it, rq);
        if (a != 0) begin
            if (lat_ref[it] == 0) lat_ref[it] = lat;
            else chk(lat == lat_ref[it], "R11",
                     $sformatf("latency for %0d: actual %0d expected %0d", a, lat, lat_ref[it]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r, r0, ra;
        int lat, lat0;
        for (int i = 0; i < 8; i++) lat_ref[i] = 0;

        // R10: reset state
        repeat (4) @(negedge clk);
        chk(ready == 1'b0, "R10", $sformatf("ready actual %0b expected 0", ready));
        chk(root == '0, "R10", $sformatf("root actual %0d expected 0", root));
        rst_n = 1'b1;

        // R6: zero operand, R7: strobe lasts one cycle
        do_op(0, 2, r, lat);
        chk(r == '0, "R6", $sformatf("zero root actual %0d expected 0", r));
        @(negedge clk);
        chk(ready == 1'b0, "R7", $sformatf("ready second cycle actual %0b expected 0", ready));

        // R1/R2: all small operands, every large leading-zero count
        for (int a = 1; a < 256; a++) run_val(a, 2, "R1");

        // R2/R4: powers of two (odd and even exponents) and all-ones words
        for (int k = 0; k < W; k++) begin
            run_val(1 << k, 2, "R4");
            run_val((1 << (k + 1)) - 1, 2, "R2");
        end

        // R1: strided sweep over the remaining range
        for (int a = 256; a < (1 << W); a += 131) run_val(a, 2, "R1");

        // R3/R5: pass counts
        foreach (lat_ref[i]) ;
        for (int j = 0; j < 5; j++) begin
            int v;
            v = (j == 0) ? 3 : (j == 1) ? 77 : (j == 2) ? 1000 : (j == 3) ? 40000 : (1 << W) - 1;
            run_val(v, 1, "R3");
            do_op(v, 1, r, lat);
            do_op(v, 0, r0, lat0);
            chk(r0 == r, "R5", $sformatf("count 0 root actual %0d expected %0d", r0, r));
            chk(lat0 == lat, "R5", $sformatf("count 0 latency actual %0d expected %0d", lat0, lat));
            run_val(v, 3, "R5");
            run_val(v, 7, "R5");
        end

        // R8: restart a few cycles into an operation
        @(negedge clk);
        req = 1'b1; operand = W'(12345); iters = 3'd2;
        @(negedge clk);
        req = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(!ready, "R8", "early answer: actual 1 expected 0");
        end
        do_op(200000, 2, r, lat);
        chk_root(200000, r, 2, "R8");
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            chk(!ready, "R8", "second answer: actual 1 expected 0");
        end

        // R8: back-to-back requests
        @(negedge clk);
        req = 1'b1; operand = W'(9); iters = 3'd2;
        do_op(150001, 2, r, lat);
        chk_root(150001, r, 2, "R8");
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            chk(!ready, "R8", "stale answer: actual 1 expected 0");
        end

        // R9: new request in the answer cycle
        do_op(5000, 2, ra, lat);
        chk_root(5000, ra, 2, "R9");
        req = 1'b1; operand = W'(70000); iters = 3'd2;
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!ready && lat < 400) begin
            chk(root == ra, "R9", $sformatf("held root actual %0d expected %0d", root, ra));
            @(negedge clk);
            lat++;
        end
        chk(ready, "R9", "no answer for second request: actual 0 expected 1");
        chk_root(70000, root, 2, "R9");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule